// File: doc/BRIEF.md
# Packed Lane Averaging Unit

This unit is a small vector execution stage. It keeps its own file of vector registers, each holding several unsigned lanes packed side by side. Its main operation takes two registers, adds each pair of lanes in a sum one bit wider than a lane, and keeps the upper bits of that sum. The result is the rounded-down mean with no wrap-around, and it is written back packed into a destination register.

The same lane datapath also serves a scalar form. That form takes the low lane of two 32-bit operands and returns their mean, zero-extended, on a separate result port. Whole vectors move between the register file and an external memory port through load and store operations. An instruction front end presents one operation at a time on a valid/ready handshake, with an opcode, register indices, a word address and two scalar operands.

A register written by one operation can be read by the very next accepted operation through a write-port bypass. This lets dependent operations issue back to back.

Top module: `simd_avg_unit`

## Requirements
- R1: After reset every vector register reads as zero, op_ready is 1, sc_valid is 0 and mem_req is 0.
- R2: Opcode 2'b00 (vector average) writes to register op_dst, for every lane k (bits [16k+15:16k], k = 0..3), floor((A_k + B_k) / 2). A is register op_srca and B is register op_srcb. No carry or borrow crosses a lane boundary, and a lane sum above 16'hFFFF is not lost (FFFF+FFFF gives FFFF, FFFF+0001 gives 8000).
- R3: A register written by an operation is the value read by any operation accepted in the next cycle or later. This holds for a vector average, a load or a store, including back-to-back dependent issue.
- R4: Opcode 2'b01 (scalar average) sets sc_valid for exactly one cycle, the cycle after acceptance. In that cycle sc_data = {16'h0, floor((sc_a[15:0] + sc_b[15:0]) / 2)}. Bits [31:16] of both operands are ignored, and no vector register changes.
- R5: Opcode 2'b11 (store) drives, in its acceptance cycle, mem_req = 1, mem_we = 1, mem_addr = op_addr and mem_wdata = register op_srca.
- R6: Opcode 2'b10 (load) drives, in its acceptance cycle, mem_req = 1, mem_we = 0 and mem_addr = op_addr. op_ready is 0 from the next cycle until the cycle after mem_rvalid. The returned mem_rdata is written to register op_dst.
- R7: mem_rvalid while no load is outstanding changes no vector register.
- R8: With no load outstanding op_ready is 1. mem_req is 0 in every cycle in which no load or store is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Operation can be accepted |
| op_code | input | 2 | 00 vector average, 01 scalar average, 10 load, 11 store |
| op_dst | input | 3 | Destination vector register |
| op_srca | input | 3 | First source register (store data source) |
| op_srcb | input | 3 | Second source register |
| op_addr | input | 16 | Memory word address for load and store |
| sc_a | input | 32 | First scalar operand |
| sc_b | input | 32 | Second scalar operand |
| sc_valid | output | 1 | Scalar result valid |
| sc_data | output | 32 | Scalar result |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 64 | Store data |
| mem_rvalid | input | 1 | Load data returned |
| mem_rdata | input | 64 | Load data |

## Verification
The hardest situation to reach is a read that must take its value from the bypass rather than from the register array. This happens when an operation is accepted in the cycle right after the one that produced its source, and it also covers the first operation after a load response. The stimulus issues dependent chains with no idle cycles: an average feeding an average feeding a store, and a load whose destination is read by the operation accepted as soon as op_ready returns. A behavioural register and memory model predicts every store's data and every scalar result. Stray mem_rvalid pulses are injected while idle, and all registers are then dumped through stores.

// File: rtl/simd_avg_pkg.sv
package simd_avg_pkg;

   typedef enum logic [1:0] {
      OP_VAVG   = 2'd0,
      OP_SAVG   = 2'd1,
      OP_VLOAD  = 2'd2,
      OP_VSTORE = 2'd3
   } simd_op_e;

endpackage

// File: rtl/simd_avg_lane.sv
module simd_avg_lane #(
   parameter int LANE_W = 16
) (
   input  logic [LANE_W-1:0] lane_a,
   input  logic [LANE_W-1:0] lane_b,
   output logic [LANE_W-1:0] lane_avg
);

   logic [LANE_W:0] wide_sum;

   assign wide_sum = {1'b0, lane_a} + {1'b0, lane_b};
   assign lane_avg = wide_sum[LANE_W:1];

   // R2
   always_comb begin
      if (!$isunknown({lane_a, lane_b})) begin
         lane_bound_chk: assert ((lane_avg >= ((lane_a < lane_b) ? lane_a : lane_b)) &&
                                 (lane_avg <= ((lane_a < lane_b) ? lane_b : lane_a)))
            else $error("lane mean outside its operands");
      end
   end

endmodule

// File: rtl/simd_avg_datapath.sv
module simd_avg_datapath #(
   parameter int LANE_W   = 16,
   parameter int LANES    = 4,
   parameter int SCALAR_W = 32,
   localparam int VEC_W   = LANE_W * LANES
) (
   input  logic                scalar_mode,
   input  logic [VEC_W-1:0]    vec_a,
   input  logic [VEC_W-1:0]    vec_b,
   input  logic [LANE_W-1:0]   sc_lane_a,
   input  logic [LANE_W-1:0]   sc_lane_b,
   output logic [VEC_W-1:0]    vec_res,
   output logic [SCALAR_W-1:0] sc_res
);

   logic [VEC_W-1:0] opnd_a;
   logic [VEC_W-1:0] opnd_b;

   assign opnd_a = scalar_mode ? VEC_W'(sc_lane_a) : vec_a;
   assign opnd_b = scalar_mode ? VEC_W'(sc_lane_b) : vec_b;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      simd_avg_lane #(.LANE_W(LANE_W)) u_lane (
         .lane_a  (opnd_a[k*LANE_W +: LANE_W]),
         .lane_b  (opnd_b[k*LANE_W +: LANE_W]),
         .lane_avg(vec_res[k*LANE_W +: LANE_W])
      );
   end

   if (SCALAR_W > LANE_W) begin : g_sc_wide
      assign sc_res = {{(SCALAR_W-LANE_W){1'b0}}, vec_res[LANE_W-1:0]};
   end else begin : g_sc_exact
      assign sc_res = vec_res[LANE_W-1:0];
   end

endmodule

// File: rtl/simd_avg_regfile.sv
module simd_avg_regfile #(
   parameter int NREGS  = 8,
   parameter int DATA_W = 64,
   parameter int RPORTS = 2,
   localparam int IDX_W = $clog2(NREGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_idx  [RPORTS],
   output logic [DATA_W-1:0] rd_data [RPORTS],
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data
);

   logic [DATA_W-1:0] regs [NREGS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NREGS; i++) regs[i] <= '0;
      end else if (wr_en) begin
         regs[wr_idx] <= wr_data;
      end
   end

   for (genvar p = 0; p < RPORTS; p++) begin : g_rport
      assign rd_data[p] = (wr_en && (wr_idx == rd_idx[p])) ? wr_data : regs[rd_idx[p]];
   end

endmodule

// File: rtl/simd_avg_unit.sv
module simd_avg_unit
   import simd_avg_pkg::*;
#(
   parameter int LANE_W   = 16,
   parameter int LANES    = 4,
   parameter int NREGS    = 8,
   parameter int SCALAR_W = 32,
   parameter int ADDR_W   = 16,
   localparam int VEC_W   = LANE_W * LANES,
   localparam int IDX_W   = $clog2(NREGS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                op_valid,
   output logic                op_ready,
   input  logic [1:0]          op_code,
   input  logic [IDX_W-1:0]    op_dst,
   input  logic [IDX_W-1:0]    op_srca,
   input  logic [IDX_W-1:0]    op_srcb,
   input  logic [ADDR_W-1:0]   op_addr,
   input  logic [SCALAR_W-1:0] sc_a,
   input  logic [SCALAR_W-1:0] sc_b,
   output logic                sc_valid,
   output logic [SCALAR_W-1:0] sc_data,
   output logic                mem_req,
   output logic                mem_we,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic [VEC_W-1:0]    mem_wdata,
   input  logic                mem_rvalid,
   input  logic [VEC_W-1:0]    mem_rdata
);

   initial begin
      param_chk: assert ((SCALAR_W >= LANE_W) && (LANES >= 1) && (LANE_W >= 2) &&
                         (NREGS >= 2) && ((1 << IDX_W) == NREGS) && (ADDR_W >= 1))
         else $error("simd_avg_unit: unsupported parameter set");
   end

   simd_op_e op;
   logic     fire;
   logic     ld_busy;
   logic [IDX_W-1:0] ld_dst;
   logic     ld_done;

   logic             wb_valid;
   logic [IDX_W-1:0] wb_idx;
   logic [VEC_W-1:0] wb_data;

   logic [IDX_W-1:0] rd_idx  [2];
   logic [VEC_W-1:0] rd_data [2];
   logic [VEC_W-1:0] avg_vec;
   logic [SCALAR_W-1:0] avg_sc;

   logic [SCALAR_W-LANE_W:0] unused_sc_hi;
   assign unused_sc_hi = {sc_a[SCALAR_W-1:LANE_W-1], 1'b0} ^ {sc_b[SCALAR_W-1:LANE_W-1], 1'b0};

   assign op       = simd_op_e'(op_code);
   assign op_ready = !ld_busy;
   assign fire     = op_valid && op_ready;
   assign ld_done  = ld_busy && mem_rvalid;

   assign rd_idx[0] = op_srca;
   assign rd_idx[1] = op_srcb;

   simd_avg_regfile #(.NREGS(NREGS), .DATA_W(VEC_W), .RPORTS(2)) u_rf (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (rd_idx),
      .rd_data(rd_data),
      .wr_en  (wb_valid),
      .wr_idx (wb_idx),
      .wr_data(wb_data)
   );

   simd_avg_datapath #(.LANE_W(LANE_W), .LANES(LANES), .SCALAR_W(SCALAR_W)) u_dp (
      .scalar_mode(op == OP_SAVG),
      .vec_a      (rd_data[0]),
      .vec_b      (rd_data[1]),
      .sc_lane_a  (sc_a[LANE_W-1:0]),
      .sc_lane_b  (sc_b[LANE_W-1:0]),
      .vec_res    (avg_vec),
      .sc_res     (avg_sc)
   );

   assign mem_req   = fire && ((op == OP_VLOAD) || (op == OP_VSTORE));
   assign mem_we    = (op == OP_VSTORE);
   assign mem_addr  = op_addr;
   assign mem_wdata = rd_data[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ld_busy  <= 1'b0;
         ld_dst   <= '0;
         wb_valid <= 1'b0;
         wb_idx   <= '0;
         wb_data  <= '0;
         sc_valid <= 1'b0;
         sc_data  <= '0;
      end else begin
         if (fire && (op == OP_VLOAD)) begin
            ld_busy <= 1'b1;
            ld_dst  <= op_dst;
         end else if (ld_done) begin
            ld_busy <= 1'b0;
         end
         wb_valid <= ld_done || (fire && (op == OP_VAVG));
         wb_idx   <= ld_done ? ld_dst : op_dst;
         wb_data  <= ld_done ? mem_rdata : avg_vec;
         sc_valid <= fire && (op == OP_SAVG);
         if (fire && (op == OP_SAVG)) sc_data <= avg_sc;
      end
   end

   // R3
   vavg_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && (op == OP_VAVG)) |=> (wb_valid && (wb_idx == $past(op_dst))));

   // R4
   scalar_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && (op == OP_SAVG)) |=> (sc_valid && !wb_valid));

   // R6
   ld_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && (op == OP_VLOAD)) |=> !op_ready);

   // R6
   ld_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_busy && !mem_rvalid) |=> (!op_ready && !wb_valid));

   // R7
   stray_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rvalid && !ld_busy && !(fire && (op == OP_VAVG))) |=> !wb_valid);

endmodule

// File: tb/tb_simd_avg_unit.sv
module tb_simd_avg_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic        op_ready;
   logic [1:0]  op_code = 2'd0;
   logic [2:0]  op_dst = '0, op_srca = '0, op_srcb = '0;
   logic [15:0] op_addr = '0;
   logic [31:0] sc_a = '0, sc_b = '0;
   logic        sc_valid;
   logic [31:0] sc_data;
   logic        mem_req, mem_we;
   logic [15:0] mem_addr;
   logic [63:0] mem_wdata;
   logic        mem_rvalid = 1'b0;
   logic [63:0] mem_rdata = '0;

   always #2 clk = ~clk;

   simd_avg_unit dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
      .op_code(op_code), .op_dst(op_dst), .op_srca(op_srca), .op_srcb(op_srcb),
      .op_addr(op_addr), .sc_a(sc_a), .sc_b(sc_b), .sc_valid(sc_valid),
      .sc_data(sc_data), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
   );

   int checks = 0;
   int errors = 0;
   string cur_req = "R1";

   logic [63:0] mem_arr [16];
   logic [63:0] ref_mem [16];
   logic [63:0] ref_rf  [8];
   logic [63:0] st_dat_q [$];
   logic [15:0] st_adr_q [$];
   logic [31:0] sc_q [$];
   bit stray = 1'b0;

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] mean16(input logic [15:0] a, input logic [15:0] b);
      int s;
      s = int'(a) + int'(b);
      return 16'(s / 2);
   endfunction

   function automatic logic [63:0] vmean(input logic [63:0] a, input logic [63:0] b);
      logic [63:0] r;
      for (int k = 0; k < 4; k++) r[k*16 +: 16] = mean16(a[k*16 +: 16], b[k*16 +: 16]);
      return r;
   endfunction

   // memory responder and store monitor
   initial begin
      int cnt = 0;
      logic [63:0] rsp = '0;
      forever begin
         @(posedge clk);
         if (rst_n && mem_req && !mem_we) begin
            cnt = 2;
            rsp = mem_arr[mem_addr[3:0]];
         end
         if (rst_n && mem_req && mem_we) begin
            if (st_dat_q.size() == 0) begin
               check("R5", {63'd0, mem_req}, 64'd0, "unexpected store request");
            end else begin
               check(cur_req, {48'd0, mem_addr}, {48'd0, st_adr_q.pop_front()}, "store address");
               check(cur_req, mem_wdata, st_dat_q.pop_front(), "store data");
            end
            mem_arr[mem_addr[3:0]] = mem_wdata;
         end
         if (rst_n && !op_valid) check("R8", {63'd0, mem_req}, 64'd0, "mem_req while idle");
         @(negedge clk);
         mem_rvalid = 1'b0;
         if (cnt > 0) begin
            cnt--;
            if (cnt == 0) begin
               mem_rvalid = 1'b1;
               mem_rdata  = rsp;
            end
         end else if (stray) begin
            mem_rvalid = 1'b1;
            mem_rdata  = 64'hDEAD_BEEF_0BAD_F00D;
         end
      end
   end

   // scalar result monitor, every cycle
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && sc_valid) begin
            if (sc_q.size() == 0) check("R4", 64'd1, 64'd0, "unexpected sc_valid");
            else check("R4", {32'd0, sc_data}, {32'd0, sc_q.pop_front()}, "scalar mean");
         end
      end
   end

   task automatic issue(input logic [1:0] c, input int d, input int a, input int b,
                        input int ad, input logic [31:0] x, input logic [31:0] y);
      @(negedge clk);
      op_valid = 1'b1; op_code = c; op_dst = 3'(d); op_srca = 3'(a); op_srcb = 3'(b);
      op_addr = 16'(ad); sc_a = x; sc_b = y;
      while (!op_ready) @(negedge clk);
      case (c)
         2'd0: ref_rf[d] = vmean(ref_rf[a], ref_rf[b]);
         2'd1: sc_q.push_back({16'h0, mean16(x[15:0], y[15:0])});
         2'd2: ref_rf[d] = ref_mem[ad];
         default: begin
            ref_mem[ad] = ref_rf[a];
            st_adr_q.push_back(16'(ad));
            st_dat_q.push_back(ref_rf[a]);
         end
      endcase
      @(posedge clk);
      #1 op_valid = 1'b0;
      if (c == 2'd2) begin
         @(negedge clk);
         check("R6", {63'd0, op_ready}, 64'd0, "op_ready during load");
      end
   endtask

   task automatic dump_regs(input string req);
      cur_req = req;
      for (int r = 0; r < 8; r++) issue(2'd3, 0, r, 0, 8 + r, '0, '0);
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) begin
         mem_arr[i] = 64'h9E37_79B9_7F4A_7C15 * 64'(i + 1);
      end
      mem_arr[0] = 64'hFFFF_FFFF_FFFF_FFFF;
      mem_arr[1] = 64'h0001_0001_0001_0001;
      mem_arr[2] = 64'h0000_0000_0000_0000;
      mem_arr[3] = 64'h8000_7FFF_FFFE_0001;
      for (int i = 0; i < 16; i++) ref_mem[i] = mem_arr[i];
      for (int i = 0; i < 8; i++) ref_rf[i] = '0;

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state of outputs; R8 ready when idle
      check("R1", {63'd0, op_ready}, 64'd1, "op_ready after reset");
      check("R1", {63'd0, sc_valid}, 64'd0, "sc_valid after reset");
      check("R8", {63'd0, mem_req}, 64'd0, "mem_req after reset");
      dump_regs("R1");

      // R6 loads with corner patterns
      for (int r = 0; r < 8; r++) issue(2'd2, r, 0, 0, r, '0, '0);
      dump_regs("R6");

      // R2 lane arithmetic
      issue(2'd0, 4, 0, 1, 0, '0, '0);
      issue(2'd0, 5, 0, 0, 0, '0, '0);
      issue(2'd0, 6, 3, 0, 0, '0, '0);
      issue(2'd0, 7, 2, 1, 0, '0, '0);
      dump_regs("R2");

      // R3 dependent back-to-back chain into a store
      cur_req = "R3";
      issue(2'd0, 1, 4, 5, 0, '0, '0);
      issue(2'd0, 2, 1, 0, 0, '0, '0);
      issue(2'd3, 0, 2, 0, 9, '0, '0);
      issue(2'd2, 3, 0, 0, 5, '0, '0);
      issue(2'd0, 0, 3, 6, 0, '0, '0);
      issue(2'd0, 0, 0, 0, 0, '0, '0);
      issue(2'd3, 0, 0, 0, 10, '0, '0);
      dump_regs("R3");

      // R4 scalar form, upper bits ignored, regs untouched
      issue(2'd1, 2, 0, 0, 0, 32'hABCD_FFFF, 32'h1234_FFFF);
      issue(2'd1, 3, 0, 0, 0, 32'hFFFF_FFFF, 32'h0000_0001);
      issue(2'd1, 4, 0, 0, 0, 32'h5555_0003, 32'hAAAA_0000);
      issue(2'd1, 5, 0, 0, 0, 32'h0000_1234, 32'hFFFF_4322);
      repeat (2) @(negedge clk);
      dump_regs("R4");

      // R7 stray load responses while idle
      @(negedge clk);
      stray = 1'b1;
      repeat (3) @(negedge clk);
      stray = 1'b0;
      repeat (2) @(negedge clk);
      dump_regs("R7");

      check("R5", 64'(st_dat_q.size()), 64'd0, "missing store requests");
      check("R4", 64'(sc_q.size()), 64'd0, "missing scalar results");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule